// File: doc/BRIEF.md
# Gated Filtered Event Counter Input

This block prepares an external event signal so that a timer can count it. The raw pin and the two gate inputs first cross into the clock domain through a synchronizer. The pin then passes through an optional glitch filter. The filter accepts a new level only after it has seen that level on three samples in a row. Its sample rate is chosen from the base clock, one in eight clocks or one in thirty-two clocks.

An edge detector watches the conditioned level for the chosen polarity. A gate decides whether a detected edge is counted. The gate can stay open at all times, or follow the level of an interrupt input whose open level depends on that input's selected edge polarity, or open only while a secondary timer output is low. Each accepted edge gives a one-cycle count pulse. That pulse advances an 8-bit up counter that wraps.

Top module: `event_gate_counter`

## Requirements
- R1: During and straight after reset, `cnt_value` is 0, `evt_level` is low and `cnt_pulse` is low.
- R2: With `flt_sel` = 00 (no filter), a pin change made between two rising clock edges appears on `evt_level` on the third rising edge that follows, and not earlier.
- R3: With `flt_sel` = 01 (sample every clock), `evt_level` takes a new pin value on the fifth rising edge after the change. A pin pulse that lasts only two clocks never reaches `evt_level`.
- R4: With `flt_sel` = 10, the filter samples once every 8 clocks. With `flt_sel` = 11, it samples once every 32 clocks. A 40-clock pin pulse therefore passes at code 10 and is rejected at code 11, and a 160-clock pulse passes at code 11.
- R5: Any change of `flt_sel` clears the filter's count of equal samples, so `evt_level` does not change on the edge where the new code is first seen. Three fresh samples are needed at the new rate.
- R6: `edge_fall` = 0 counts rising edges of `evt_level`. `edge_fall` = 1 counts falling edges only.
- R7: With `gate_mode` = 00, every selected edge of `evt_level` gives a pulse on `cnt_pulse` one clock later.
- R8: With `gate_mode` = 01, edges are accepted while `gate_lvl_in` is high if `gate_pol_rise` = 0, and while `gate_lvl_in` is low if `gate_pol_rise` = 1.
- R9: With `gate_mode` = 10, edges are accepted only while `aux_tmr_in` is low.
- R10: With `gate_mode` = 11 (reserved), no count pulse is ever produced.
- R11: An edge that arrives while the gate is closed is dropped. Opening the gate later produces no pulse for that edge.
- R12: Each accepted edge gives exactly one `cnt_pulse` that is high for one clock. `cnt_value` increases by one after each pulse, holds otherwise, and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pin | input | 1 | Raw external event signal |
| gate_lvl_in | input | 1 | Interrupt input used as a level gate |
| aux_tmr_in | input | 1 | Secondary timer output used as a gate |
| flt_sel | input | 2 | Filter select: 00 off, 01 every clock, 10 every 8, 11 every 32 |
| edge_fall | input | 1 | 0 counts rising edges, 1 counts falling edges |
| gate_mode | input | 2 | 00 always, 01 interrupt level, 10 timer output low, 11 closed |
| gate_pol_rise | input | 1 | Edge polarity of the interrupt input: 0 falling, 1 rising |
| cnt_pulse | output | 1 | One-cycle pulse per accepted edge |
| cnt_value | output | 8 | Wrapping event count |
| evt_level | output | 1 | Conditioned (filtered) event level |

## Verification
The bound checker watches every cycle for these properties: the count pulse is always one clock wide, the counter steps by exactly one per pulse and holds otherwise, the reserved gate code never lets a pulse through, and the filtered level stays put on the edge where a new filter code is first seen. It also checks that an open gate turns each selected transition of the filtered level into a pulse on the next clock. Some behaviours can only be shown by the bench's scenarios, because they span long stretches of time. These are the exact synchronizer and filter latencies, glitch rejection at each sample rate, the gate polarity choices, the dropping of edges while the gate is closed, and the 255-to-0 wrap.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;

    typedef enum logic [1:0] {
        FLT_OFF  = 2'b00,
        FLT_BASE = 2'b01,
        FLT_MID  = 2'b10,
        FLT_SLOW = 2'b11
    } flt_sel_e;

    typedef enum logic [1:0] {
        GATE_ALWAYS = 2'b00,
        GATE_INT    = 2'b01,
        GATE_AUX    = 2'b10,
        GATE_RSVD   = 2'b11
    } gate_mode_e;

endpackage

// File: rtl/evc_sync.sv
`timescale 1ns/1ps
// Multi-bit synchronizer: each bit passes through STAGES flops.
module evc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            nxt_d.stg[i] = cur_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign dout = cur_q.stg[STAGES-1];
endmodule

// File: rtl/evc_presc.sv
`timescale 1ns/1ps
// Free-running prescaler producing one-cycle sample enables.
module evc_presc #(
    parameter int MID_DIV  = 8,
    parameter int SLOW_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic en_mid,
    output logic en_slow
);
    localparam int CW = $clog2(SLOW_DIV);
    localparam int MW = $clog2(MID_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } presc_t;

    presc_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.cnt = cur_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign en_mid  = &cur_q.cnt[MW-1:0];
    assign en_slow = &cur_q.cnt;
endmodule

// File: rtl/evc_filt.sv
`timescale 1ns/1ps
// Run-length glitch filter: the level follows the input only after
// RUN_LEN equal samples taken at the selected rate.
module evc_filt
    import evc_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     din,
    input  flt_sel_e sel,
    input  logic     en_mid,
    input  logic     en_slow,
    output logic     level
);
    localparam int RW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic          level;
        logic          cand;
        logic [RW-1:0] run;
        flt_sel_e      sel;
    } filt_t;

    filt_t cur_q, nxt_d;
    logic  smp_en;

    always_comb begin
        case (sel)
            FLT_OFF:  smp_en = 1'b0;
            FLT_BASE: smp_en = 1'b1;
            FLT_MID:  smp_en = en_mid;
            default:  smp_en = en_slow;
        endcase
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.sel = sel;
        if (sel != cur_q.sel) begin
            // new sample rate: earlier samples no longer count
            nxt_d.run = '0;
        end else if (sel == FLT_OFF) begin
            nxt_d.level = din;
            nxt_d.cand  = din;
            nxt_d.run   = RW'(RUN_LEN);
        end else if (smp_en) begin
            if (din == cur_q.cand) begin
                if (cur_q.run < RW'(RUN_LEN)) nxt_d.run = cur_q.run + RW'(1);
            end else begin
                nxt_d.cand = din;
                nxt_d.run  = RW'(1);
            end
            if (nxt_d.run == RW'(RUN_LEN)) nxt_d.level = nxt_d.cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.level <= 1'b0;
            cur_q.cand  <= 1'b0;
            cur_q.run   <= '0;
            cur_q.sel   <= FLT_OFF;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign level = cur_q.level;
endmodule

// File: rtl/evc_qual.sv
`timescale 1ns/1ps
// Edge detector with gate qualification; emits a registered one-cycle pulse.
module evc_qual
    import evc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic       edge_fall,
    input  gate_mode_e mode,
    input  logic       gate_pol_rise,
    input  logic       int_s,
    input  logic       aux_s,
    output logic       pulse
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } qual_t;

    qual_t cur_q, nxt_d;
    logic  gate_open;
    logic  hit;

    always_comb begin
        case (mode)
            GATE_ALWAYS: gate_open = 1'b1;
            GATE_INT:    gate_open = gate_pol_rise ? ~int_s : int_s;
            GATE_AUX:    gate_open = ~aux_s;
            default:     gate_open = 1'b0;
        endcase
        hit = edge_fall ? (cur_q.prev & ~level) : (~cur_q.prev & level);
    end

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.prev  = level;
        nxt_d.pulse = hit & gate_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pulse = cur_q.pulse;
endmodule

// File: rtl/event_gate_counter.sv
`timescale 1ns/1ps
module event_gate_counter
    import evc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RUN_LEN     = 3,
    parameter int MID_DIV     = 8,
    parameter int SLOW_DIV    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_pin,
    input  logic             gate_lvl_in,
    input  logic             aux_tmr_in,
    input  logic [1:0]       flt_sel,
    input  logic             edge_fall,
    input  logic [1:0]       gate_mode,
    input  logic             gate_pol_rise,
    output logic             cnt_pulse,
    output logic [CNT_W-1:0] cnt_value,
    output logic             evt_level
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] sync_out;
    logic             en_mid;
    logic             en_slow;
    logic             flt_level;
    logic             pulse;

    assign raw_in = {aux_tmr_in, gate_lvl_in, evt_pin};

    evc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    evc_presc #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_mid (en_mid),
        .en_slow(en_slow)
    );

    evc_filt #(.RUN_LEN(RUN_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (sync_out[0]),
        .sel    (flt_sel_e'(flt_sel)),
        .en_mid (en_mid),
        .en_slow(en_slow),
        .level  (flt_level)
    );

    evc_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .level        (flt_level),
        .edge_fall    (edge_fall),
        .mode         (gate_mode_e'(gate_mode)),
        .gate_pol_rise(gate_pol_rise),
        .int_s        (sync_out[1]),
        .aux_s        (sync_out[2]),
        .pulse        (pulse)
    );

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (pulse) nxt_d.cnt = cur_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_pulse = pulse;
    assign cnt_value = cur_q.cnt;
    assign evt_level = flt_level;
endmodule

// File: rtl/evc_chk.sv
`timescale 1ns/1ps
module evc_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       flt_sel,
    input logic             edge_fall,
    input logic [1:0]       gate_mode,
    input logic             cnt_pulse,
    input logic [CNT_W-1:0] cnt_value,
    input logic             evt_level
);
    // R12
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_pulse |=> !cnt_pulse);

    // R12
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_pulse |=> (cnt_value == CNT_W'($past(cnt_value) + CNT_W'(1))));

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_pulse |=> $stable(cnt_value));

    // R10
    rsvd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate_mode) == 2'b11) |-> !cnt_pulse);

    // R5
    filt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_sel != $past(flt_sel)) |=> $stable(evt_level));

    // R7
    open_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_level) && !edge_fall && gate_mode == 2'b00) |=> cnt_pulse);

    // R6
    open_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(evt_level) && edge_fall && gate_mode == 2'b00) |=> cnt_pulse);

    // R6
    wrong_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_level) && edge_fall) |=> !cnt_pulse);
endmodule

bind event_gate_counter evc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_sel  (flt_sel),
    .edge_fall(edge_fall),
    .gate_mode(gate_mode),
    .cnt_pulse(cnt_pulse),
    .cnt_value(cnt_value),
    .evt_level(evt_level)
);

// File: tb/event_gate_counter_tb.sv
`timescale 1ns/1ps
module event_gate_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_pin;
    logic       gate_lvl_in;
    logic       aux_tmr_in;
    logic [1:0] flt_sel;
    logic       edge_fall;
    logic [1:0] gate_mode;
    logic       gate_pol_rise;
    logic       cnt_pulse;
    logic [7:0] cnt_value;
    logic       evt_level;

    int   checks = 0;
    int   errors = 0;
    int   pulses = 0;
    int   wide_pulses = 0;
    int   exp_pulses = 0;
    logic prev_pulse = 1'b0;
    logic [7:0] exp_cnt = 8'd0;

    always #4 clk = ~clk;

    event_gate_counter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_pin      (evt_pin),
        .gate_lvl_in  (gate_lvl_in),
        .aux_tmr_in   (aux_tmr_in),
        .flt_sel      (flt_sel),
        .edge_fall    (edge_fall),
        .gate_mode    (gate_mode),
        .gate_pol_rise(gate_pol_rise),
        .cnt_pulse    (cnt_pulse),
        .cnt_value    (cnt_value),
        .evt_level    (evt_level)
    );

    always @(negedge clk) begin
        if (rst_n && cnt_pulse) begin
            pulses++;
            if (prev_pulse) wide_pulses++;
        end
        prev_pulse = cnt_pulse;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // full high-then-low pin cycle; 'counted' tells whether one edge is accepted
    task automatic pin_pair(input bit counted);
        evt_pin = 1'b1; tick(6);
        evt_pin = 1'b0; tick(6);
        if (counted) begin
            exp_cnt++;
            exp_pulses++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; evt_pin = 1'b0; gate_lvl_in = 1'b0; aux_tmr_in = 1'b0;
        flt_sel = 2'b00; edge_fall = 1'b0; gate_mode = 2'b00; gate_pol_rise = 1'b0;
        tick(3);
        chk("R1 count in reset", cnt_value, 0);
        chk("R1 level in reset", evt_level, 0);
        chk("R1 pulse in reset", cnt_pulse, 0);
        rst_n = 1'b1; tick(1);
        chk("R1 count after reset", cnt_value, 0);
        tick(5);
    endtask

    task automatic t_nofilt();
        evt_pin = 1'b1; tick(2);
        chk("R2 level before third edge", evt_level, 0);
        tick(1);
        chk("R2 level on third edge", evt_level, 1);
        tick(4); exp_cnt++; exp_pulses++;
        chk("R7 count after rising edge", cnt_value, exp_cnt);
        evt_pin = 1'b0; tick(6);
        chk("R7 falling edge not counted", cnt_value, exp_cnt);
    endtask

    task automatic t_base_filter();
        int p0;
        flt_sel = 2'b01; tick(10);
        evt_pin = 1'b1; tick(4);
        chk("R3 level before fifth edge", evt_level, 0);
        tick(1);
        chk("R3 level on fifth edge", evt_level, 1);
        tick(3); exp_cnt++; exp_pulses++;
        chk("R3 count after filtered edge", cnt_value, exp_cnt);
        evt_pin = 1'b0; tick(10);
        p0 = pulses;
        evt_pin = 1'b1; tick(2); evt_pin = 1'b0; tick(12);
        chk("R3 two-clock glitch rejected", pulses - p0, 0);
        chk("R3 level after glitch", evt_level, 0);
    endtask

    task automatic t_slow_filter();
        int p0;
        flt_sel = 2'b10; tick(100);
        p0 = pulses;
        evt_pin = 1'b1; tick(40); evt_pin = 1'b0; tick(80);
        chk("R4 40-clock pulse passes at divide-by-8", pulses - p0, 1);
        exp_cnt++; exp_pulses++;
        flt_sel = 2'b11; tick(100);
        p0 = pulses;
        evt_pin = 1'b1; tick(40); evt_pin = 1'b0; tick(200);
        chk("R4 40-clock pulse rejected at divide-by-32", pulses - p0, 0);
        p0 = pulses;
        evt_pin = 1'b1; tick(160); evt_pin = 1'b0; tick(200);
        chk("R4 160-clock pulse passes at divide-by-32", pulses - p0, 1);
        exp_cnt++; exp_pulses++;
        chk("R4 count", cnt_value, exp_cnt);
    endtask

    task automatic t_sel_clear();
        flt_sel = 2'b01; tick(10);
        evt_pin = 1'b1; tick(4);
        flt_sel = 2'b10; tick(12);
        chk("R5 run count cleared on code change", evt_level, 0);
        tick(40);
        chk("R5 level after fresh samples", evt_level, 1);
        exp_cnt++; exp_pulses++;
        evt_pin = 1'b0; tick(60);
        chk("R5 count", cnt_value, exp_cnt);
        flt_sel = 2'b00; tick(6);
    endtask

    task automatic t_edge_sel();
        edge_fall = 1'b1; tick(4);
        evt_pin = 1'b1; tick(8);
        chk("R6 rising edge ignored when falling selected", cnt_value, exp_cnt);
        evt_pin = 1'b0; tick(8); exp_cnt++; exp_pulses++;
        chk("R6 falling edge counted", cnt_value, exp_cnt);
        edge_fall = 1'b0; tick(4);
    endtask

    task automatic t_gate_int();
        gate_mode = 2'b01; gate_pol_rise = 1'b0; gate_lvl_in = 1'b1; tick(5);
        pin_pair(1'b1);
        chk("R8 falling polarity, input high opens", cnt_value, exp_cnt);
        gate_lvl_in = 1'b0; tick(5);
        pin_pair(1'b0);
        chk("R8 falling polarity, input low closes", cnt_value, exp_cnt);
        gate_pol_rise = 1'b1; tick(2);
        pin_pair(1'b1);
        chk("R8 rising polarity, input low opens", cnt_value, exp_cnt);
        gate_lvl_in = 1'b1; tick(5);
        pin_pair(1'b0);
        chk("R8 rising polarity, input high closes", cnt_value, exp_cnt);
    endtask

    task automatic t_gate_aux();
        gate_mode = 2'b10; aux_tmr_in = 1'b0; tick(5);
        pin_pair(1'b1);
        chk("R9 timer output low opens", cnt_value, exp_cnt);
        aux_tmr_in = 1'b1; tick(5);
        pin_pair(1'b0);
        chk("R9 timer output high closes", cnt_value, exp_cnt);
    endtask

    task automatic t_gate_rsvd();
        gate_mode = 2'b11; aux_tmr_in = 1'b0; gate_lvl_in = 1'b0; gate_pol_rise = 1'b1;
        tick(5);
        pin_pair(1'b0);
        pin_pair(1'b0);
        chk("R10 reserved gate code blocks", cnt_value, exp_cnt);
    endtask

    task automatic t_drop();
        gate_mode = 2'b10; aux_tmr_in = 1'b1; tick(5);
        evt_pin = 1'b1; tick(8);
        aux_tmr_in = 1'b0; tick(8);
        chk("R11 closed-gate edge dropped", cnt_value, exp_cnt);
        evt_pin = 1'b0; tick(8);
        evt_pin = 1'b1; tick(8); exp_cnt++; exp_pulses++;
        chk("R11 later edge counted", cnt_value, exp_cnt);
        evt_pin = 1'b0; tick(8);
        gate_mode = 2'b00; tick(4);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 300 && cnt_value != 8'd255; i++) pin_pair(1'b1);
        chk("R12 count reaches 255", cnt_value, 255);
        pin_pair(1'b1);
        chk("R12 count wraps to 0", cnt_value, 0);
        chk("R12 tracked count", cnt_value, exp_cnt);
        chk("R12 one pulse per accepted edge", pulses, exp_pulses);
        chk("R12 pulses one clock wide", wide_pulses, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_nofilt();
        t_base_filter();
        t_slow_filter();
        t_sel_clear();
        t_edge_sel();
        t_gate_int();
        t_gate_aux();
        t_gate_rsvd();
        t_drop();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule